// File: doc/BRIEF.md
# Endian-Selectable Bus Width Converter

This block connects a 36-bit long-word stream to a narrower stream. The narrow side can carry 9-bit bytes, 18-bit words, or full long words. It has two independent paths. The split path takes one long word and sends it out as a series of narrow transfers. The pack path collects a series of narrow transfers and delivers them as one long word. The order of the sub-words within a long word comes from an endian bit. In full long-word width there is nothing to order, so words pass through unchanged and the endian bit plays no part.

Both data interfaces on each path are valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. While valid is high and ready is low, the sender holds its valid and its data steady. The split path can take a new long word in the same cycle that its last sub-word leaves, so it runs with no gap between words. The pack path holds a finished long word in one register and lowers its narrow ready until that word is taken. The width and endian inputs are plain control pins. They are sampled only while `rst_n` is low and are held fixed from the release of reset onward.

Top module: `bwc_width_conv`

## Requirements
- R1: In big-endian mode with byte or word width, the split path sends the most significant sub-word of each long word first and the least significant sub-word last.
- R2: In little-endian mode with byte or word width, the split path sends the least significant sub-word first and the most significant sub-word last.
- R3: In big-endian mode with byte or word width, the pack path places the first accepted sub-word in the most significant position of the long word, and each later sub-word one position lower.
- R4: In little-endian mode with byte or word width, the pack path places the first accepted sub-word in the least significant position, and each later sub-word one position higher.
- R5: The width code selects the mode: 0 is byte, 1 is word, and 2 or 3 is long. In long mode every word passes through both paths unchanged, for either endian value.
- R6: In byte mode a long word is four 9-bit sub-words, and each sub-word travels on narrow bits [8:0]. In word mode a long word is two 18-bit sub-words on narrow bits [17:0]. The split path drives the unused narrow output bits to zero. The pack path ignores narrow input bits above the sub-word width.
- R7: The pack path raises `long_out_valid` only after it accepts the final sub-word of a group. `long_out_valid` stays low after each earlier sub-word, and `nar_in_ready` stays low while a finished long word is waiting.
- R8: While `rst_n` is low, both valid outputs are low and both ready outputs are high, and the sub-word position returns to the first sub-word. The width and endian inputs take effect only as sampled during reset. Changing them after reset has no effect.
- R9: While an output valid is high and its ready is low, that valid stays high and its data stays unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; configuration is sampled while low |
| cfg_width | input | 2 | Narrow width code: 0 byte, 1 word, 2 or 3 long |
| cfg_big_endian | input | 1 | 1 selects big-endian sub-word order, 0 selects little-endian |
| long_in_valid | input | 1 | Split path: long word offered |
| long_in_ready | output | 1 | Split path: long word accepted when high with valid |
| long_in_data | input | 36 | Split path: long word |
| nar_out_valid | output | 1 | Split path: sub-word offered |
| nar_out_ready | input | 1 | Split path: sub-word taken when high with valid |
| nar_out_data | output | 36 | Split path: sub-word on the low bits, zero above them |
| nar_in_valid | input | 1 | Pack path: sub-word offered |
| nar_in_ready | output | 1 | Pack path: sub-word accepted when high with valid |
| nar_in_data | input | 36 | Pack path: sub-word on the low bits |
| long_out_valid | output | 1 | Pack path: assembled long word offered |
| long_out_ready | input | 1 | Pack path: long word taken when high with valid |
| long_out_data | output | 36 | Pack path: assembled long word |

## Verification
The bench builds the block with its default parameters: 9-bit lanes and four lanes per long word. At that size every width code (0 to 3) and both endian values can be swept in full, with a fresh reset for each of the eight combinations. Each combination runs several long words through both paths while the sinks apply a fixed, repeating back-pressure pattern. After each reset the configuration pins are driven to different values, so the held configuration is tested on every run. In the narrow modes, garbage is driven on the pack path's unused input bits. Expected sub-words and assembled words are computed arithmetically from shift and mask formulas on each word index.

// File: rtl/bwc_pkg.sv
`timescale 1ns/1ps
package bwc_pkg;
  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_WORD = 2'd1,
    WID_LONG = 2'd2
  } width_e;
endpackage

// File: rtl/bwc_cfg_latch.sv
`timescale 1ns/1ps
module bwc_cfg_latch #(
  parameter int LANES_LOG2 = 2,
  parameter int SHW        = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     width_i,
  input  logic           big_i,
  output logic [SHW-1:0] sh_o,
  output logic           big_o
);
  import bwc_pkg::*;

  logic [SHW-1:0] sh_d;

  // log2 of base lanes per sub-word
  always_comb begin
    case (width_i)
      WID_BYTE: sh_d = '0;
      WID_WORD: sh_d = SHW'((LANES_LOG2 > 0) ? 1 : 0);
      default:  sh_d = SHW'(LANES_LOG2);
    endcase
  end

  // configuration tracks the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_o  <= sh_d;
      big_o <= big_i;
    end
  end

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(sh_o) && $stable(big_o)));
endmodule

// File: rtl/bwc_splitter.sv
`timescale 1ns/1ps
module bwc_splitter #(
  parameter int LANE_W     = 9,
  parameter int LANES_LOG2 = 2,
  parameter int CW         = 2,
  parameter int SHW        = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SHW-1:0]                 sh_i,
  input  logic                           big_i,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [LANE_W*(1<<LANES_LOG2)-1:0] in_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [LANE_W*(1<<LANES_LOG2)-1:0] out_data
);
  localparam int LANES  = 1 << LANES_LOG2;
  localparam int LONG_W = LANE_W * LANES;

  logic [LONG_W-1:0] word_q;
  logic              busy_q;
  logic [CW-1:0]     cnt_q, last_idx, idx;
  logic              last;

  always_comb begin
    last_idx = CW'((LANES >> sh_i) - 1);
    last     = (cnt_q == last_idx);
    idx      = big_i ? (last_idx - cnt_q) : cnt_q;
  end

  assign out_valid = busy_q;
  assign in_ready  = !busy_q || (out_ready && last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      if (out_valid && out_ready) begin
        if (last) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
      if (in_valid && in_ready) begin
        busy_q <= 1'b1;
        word_q <= in_data;
        cnt_q  <= '0;
      end
    end
  end

  // pick the base lanes of the current sub-word onto the low narrow lanes
  always_comb begin
    out_data = '0;
    for (int l = 0; l < LANES; l++) begin
      if (l < (1 << sh_i))
        out_data[l*LANE_W +: LANE_W] =
          word_q[((int'(idx) << sh_i) + l)*LANE_W +: LANE_W];
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (sh_i != SHW'(LANES_LOG2))) |-> (out_data[LONG_W-1:LONG_W/2] == '0));
endmodule

// File: rtl/bwc_packer.sv
`timescale 1ns/1ps
module bwc_packer #(
  parameter int LANE_W     = 9,
  parameter int LANES_LOG2 = 2,
  parameter int CW         = 2,
  parameter int SHW        = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [SHW-1:0]                 sh_i,
  input  logic                           big_i,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [LANE_W*(1<<LANES_LOG2)-1:0] in_data,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [LANE_W*(1<<LANES_LOG2)-1:0] out_data
);
  localparam int LANES  = 1 << LANES_LOG2;
  localparam int LONG_W = LANE_W * LANES;

  logic [LONG_W-1:0] acc_q;
  logic              full_q;
  logic [CW-1:0]     cnt_q, last_idx, idx;
  logic              last;

  always_comb begin
    last_idx = CW'((LANES >> sh_i) - 1);
    last     = (cnt_q == last_idx);
    idx      = big_i ? (last_idx - cnt_q) : cnt_q;
  end

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (out_valid && out_ready) full_q <= 1'b0;
      if (in_valid && in_ready) begin
        for (int l = 0; l < LANES; l++) begin
          if (l < (1 << sh_i))
            acc_q[((int'(idx) << sh_i) + l)*LANE_W +: LANE_W] <= in_data[l*LANE_W +: LANE_W];
        end
        if (last) begin
          full_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_rise_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_drop_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/bwc_width_conv.sv
`timescale 1ns/1ps
module bwc_width_conv #(
  parameter int LANE_W     = 9,
  parameter int LANES_LOG2 = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [1:0]                        cfg_width,
  input  logic                              cfg_big_endian,
  input  logic                              long_in_valid,
  output logic                              long_in_ready,
  input  logic [LANE_W*(1<<LANES_LOG2)-1:0] long_in_data,
  output logic                              nar_out_valid,
  input  logic                              nar_out_ready,
  output logic [LANE_W*(1<<LANES_LOG2)-1:0] nar_out_data,
  input  logic                              nar_in_valid,
  output logic                              nar_in_ready,
  input  logic [LANE_W*(1<<LANES_LOG2)-1:0] nar_in_data,
  output logic                              long_out_valid,
  input  logic                              long_out_ready,
  output logic [LANE_W*(1<<LANES_LOG2)-1:0] long_out_data
);
  localparam int CW  = (LANES_LOG2 > 0) ? LANES_LOG2 : 1;
  localparam int SHW = (LANES_LOG2 > 0) ? $clog2(LANES_LOG2 + 1) : 1;

  logic [SHW-1:0] sh;
  logic           big;

  bwc_cfg_latch #(.LANES_LOG2(LANES_LOG2), .SHW(SHW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .width_i(cfg_width), .big_i(cfg_big_endian),
    .sh_o(sh), .big_o(big)
  );

  bwc_splitter #(.LANE_W(LANE_W), .LANES_LOG2(LANES_LOG2), .CW(CW), .SHW(SHW)) u_split (
    .clk(clk), .rst_n(rst_n), .sh_i(sh), .big_i(big),
    .in_valid(long_in_valid), .in_ready(long_in_ready), .in_data(long_in_data),
    .out_valid(nar_out_valid), .out_ready(nar_out_ready), .out_data(nar_out_data)
  );

  bwc_packer #(.LANE_W(LANE_W), .LANES_LOG2(LANES_LOG2), .CW(CW), .SHW(SHW)) u_pack (
    .clk(clk), .rst_n(rst_n), .sh_i(sh), .big_i(big),
    .in_valid(nar_in_valid), .in_ready(nar_in_ready), .in_data(nar_in_data),
    .out_valid(long_out_valid), .out_ready(long_out_ready), .out_data(long_out_data)
  );
endmodule

// File: tb/bwc_width_conv_test.sv
`timescale 1ns/1ps
module bwc_width_conv_test;
  localparam int NW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic        cfg_big_endian = 1'b0;
  logic        long_in_valid = 1'b0, long_in_ready;
  logic [35:0] long_in_data = '0;
  logic        nar_out_valid, nar_out_ready = 1'b0;
  logic [35:0] nar_out_data;
  logic        nar_in_valid = 1'b0, nar_in_ready;
  logic [35:0] nar_in_data = '0;
  logic        long_out_valid, long_out_ready = 1'b0;
  logic [35:0] long_out_data;

  bwc_width_conv uut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_big_endian(cfg_big_endian),
    .long_in_valid(long_in_valid), .long_in_ready(long_in_ready), .long_in_data(long_in_data),
    .nar_out_valid(nar_out_valid), .nar_out_ready(nar_out_ready), .nar_out_data(nar_out_data),
    .nar_in_valid(nar_in_valid), .nar_in_ready(nar_in_ready), .nar_in_data(nar_in_data),
    .long_out_valid(long_out_valid), .long_out_ready(long_out_ready), .long_out_data(long_out_data)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  int g_n, g_s;
  bit g_big;

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (n=%0d big=%0d)", req, act, exp, g_n, g_big);
    end
  endtask

  function automatic logic [35:0] word_of(int i);
    logic [71:0] t;
    t = 72'(i) * 72'h1_2345_6789 + 72'h9_ABCD_EF01;
    return t[35:0];
  endfunction

  function automatic logic [35:0] sub(logic [35:0] v, int idx, int s);
    logic [71:0] m;
    m = (72'd1 << s) - 72'd1;
    return 36'((72'(v) >> (idx * s)) & m);
  endfunction

  function automatic int idx_of(int k);
    return g_big ? (g_n - 1 - k) : k;
  endfunction

  function automatic logic [35:0] subval(int g, int k, int seed);
    return sub(word_of(g * 7 + k * 3 + seed), 0, g_s);
  endfunction

  function automatic logic [35:0] pack_exp(int g, int seed);
    logic [71:0] r;
    r = '0;
    for (int k = 0; k < g_n; k++) r = r | (72'(subval(g, k, seed)) << (idx_of(k) * g_s));
    return r[35:0];
  endfunction

  task automatic do_reset(int wsel, bit big);
    rst_n = 1'b0;
    cfg_width = 2'(wsel);
    cfg_big_endian = big;
    long_in_valid = 0; nar_in_valid = 0; nar_out_ready = 0; long_out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    // R8: reset state at the ports
    chk(long_in_ready == 1'b1, "R8 long_in_ready in reset", 36'(long_in_ready), 36'd1);
    chk(nar_out_valid == 1'b0, "R8 nar_out_valid in reset", 36'(nar_out_valid), 36'd0);
    chk(nar_in_ready == 1'b1, "R8 nar_in_ready in reset", 36'(nar_in_ready), 36'd1);
    chk(long_out_valid == 1'b0, "R8 long_out_valid in reset", 36'(long_out_valid), 36'd0);
    rst_n = 1'b1;
    // R8: scramble config pins after release; latched values must hold
    cfg_width = 2'(wsel) ^ 2'b01;
    cfg_big_endian = ~big;
  endtask

  task automatic run_split(int seed);
    string tag;
    tag = (g_n == 1) ? "R5 split (R8 held cfg)" : (g_big ? "R1 split (R8 held cfg)" : "R2 split (R8 held cfg)");
    fork
      begin
        for (int i = 0; i < NW; i++) begin
          @(negedge clk);
          long_in_valid = 1'b1;
          long_in_data = word_of(i + seed);
          #2;
          while (!long_in_ready) begin @(negedge clk); #2; end
          @(posedge clk);
        end
        @(negedge clk);
        long_in_valid = 1'b0;
      end
      begin
        int got = 0, cyc = 0;
        bit pend = 0;
        logic [35:0] held = '0, exp;
        while (got < NW * g_n) begin
          @(negedge clk);
          nar_out_ready = ((cyc % 3) != 1);
          cyc++;
          #2;
          if (pend) chk(nar_out_valid && nar_out_data == held, "R9 split hold", nar_out_data, held);
          pend = 0;
          if (nar_out_valid) begin
            if (nar_out_ready) begin
              exp = sub(word_of(got / g_n + seed), idx_of(got % g_n), g_s);
              chk(nar_out_data == exp, tag, nar_out_data, exp);
              if (g_n > 1) chk((nar_out_data >> g_s) == 0, "R6 upper bits zero", nar_out_data, exp);
              got++;
            end else begin
              pend = 1;
              held = nar_out_data;
            end
          end
        end
        @(negedge clk);
        nar_out_ready = 1'b0;
      end
    join
  endtask

  task automatic run_pack(int seed);
    string tag;
    tag = (g_n == 1) ? "R5 pack (R8 held cfg)" : (g_big ? "R3 pack (R8 held cfg)" : "R4 pack (R8 held cfg)");
    fork
      begin
        logic [71:0] msk;
        msk = (72'd1 << g_s) - 72'd1;
        for (int g = 0; g < NW; g++) begin
          for (int k = 0; k < g_n; k++) begin
            @(negedge clk);
            nar_in_valid = 1'b1;
            // R6: garbage above the sub-word width must be ignored
            nar_in_data = subval(g, k, seed) | (word_of(g + k + 77) & ~msk[35:0]);
            #2;
            while (!nar_in_ready) begin @(negedge clk); #2; end
            @(posedge clk);
            if (k < g_n - 1) begin
              #1;
              chk(!long_out_valid, "R7 no valid before last", 36'(long_out_valid), 36'd0);
            end
          end
        end
        @(negedge clk);
        nar_in_valid = 1'b0;
      end
      begin
        int got = 0, cyc = 0;
        bit pend = 0;
        logic [35:0] held = '0, exp;
        while (got < NW) begin
          @(negedge clk);
          long_out_ready = ((cyc % 4) != 0);
          cyc++;
          #2;
          if (pend) chk(long_out_valid && long_out_data == held, "R9 pack hold", long_out_data, held);
          pend = 0;
          if (long_out_valid) begin
            if (long_out_ready) begin
              exp = pack_exp(got, seed);
              chk(long_out_data == exp, tag, long_out_data, exp);
              got++;
            end else begin
              chk(!nar_in_ready, "R7 ready low while full", 36'(nar_in_ready), 36'd0);
              pend = 1;
              held = long_out_data;
            end
          end
        end
        @(negedge clk);
        long_out_ready = 1'b0;
      end
    join
  endtask

  initial begin
    for (int w = 0; w < 4; w++) begin
      for (int b = 0; b < 2; b++) begin
        g_n = (w == 0) ? 4 : ((w == 1) ? 2 : 1);
        g_s = 36 / g_n;
        g_big = b[0];
        do_reset(w, b[0]);
        run_split(w * 10 + b);
        run_pack(w * 10 + b + 3);
      end
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule